// File: doc/BRIEF.md
# Parallel Line-Segment SSD Matcher

The block scores one stream of search pixels against several short reference segments at the same time. Each reference segment is a run of consecutive grey-level pixels from one image row. Before a frame is scanned, the segments are written one pixel at a time into a store that each lane keeps for itself. The search frame then arrives one pixel per accepted cycle in raster order: left to right within a row, then rows from top to bottom. A single shift register keeps the most recent segment-length pixels of the current row. Every lane compares that window against its own reference.

For each window that lies wholly inside one row, the block computes the sum of squared pixel differences for every lane at once. It presents all lane scores in one registered bus, together with the column and row of the window's leftmost pixel and a one-cycle valid strobe. A unit downstream keeps the best candidates. A frame-start pulse returns the scan position to the top-left corner.

Top module: `ssd_line_matcher`

## Requirements
- R1: While reset is held and right after it is released, `score_valid` is 0, `win_x` and `win_y` are 0 and every lane field of `score_bus` is 0.
- R2: Lane k's score occupies `score_bus[k*SCORE_W +: SCORE_W]`, where SCORE_W = 16 + ceil(log2(SEG_LEN)), which is 19 by default. The score equals the sum over i = 0..SEG_LEN-1 of (ref_k[i] - win[i])². Index i = 0 is the leftmost, oldest pixel of the window.
- R3: The first SEG_LEN-1 accepted pixels of each row produce no valid score. Every later accepted pixel in that row produces exactly one valid score, so no scored window spans two rows.
- R4: With a valid score, `win_x` is the column of the window's first pixel, which is the current column minus (SEG_LEN-1). `win_y` is the row of that pixel.
- R5: A pixel is sampled on the rising edge where `pix_valid` is 1. Its score and coordinates are visible, with `score_valid` = 1, after the next rising edge, and `score_valid` stays high for one cycle only.
- R6: A cycle with `pix_valid` = 0 changes neither the window nor the scan position and produces no valid score.
- R7: `frame_start` = 1 sets the column and row to 0 and empties the window fill. A pixel presented in the same cycle is discarded. The next accepted pixel is treated as column 0 of row 0.
- R8: The largest possible score, SEG_LEN × 255², which is 520200 by default, is reported exactly without wrap-around. Lane score fields hold their last value while `score_valid` is 0.
- R9: With `ref_load` = 1, `ref_pix` is written to position `ref_pos` (0 = leftmost) of lane `ref_idx` on the rising edge. No other lane or position changes. A write takes effect for windows whose last pixel is sampled on that edge or later.
- R10: After column ROW_LEN-1 the column returns to 0 and the row increments by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Restart the scan at row 0, column 0 |
| pix_valid | input | 1 | `pix_data` carries a search pixel this cycle |
| pix_data | input | 8 | Search pixel, 0 black to 255 white |
| ref_load | input | 1 | Write one reference pixel |
| ref_idx | input | clog2(NUM_REF) | Lane written |
| ref_pos | input | clog2(SEG_LEN) | Position within the lane's segment |
| ref_pix | input | 8 | Reference pixel value |
| score_valid | output | 1 | Scores and coordinates are valid this cycle |
| score_bus | output | NUM_REF*SCORE_W | All lane scores, lane k at bits k*SCORE_W |
| win_x | output | COORD_W | Column of the window's first pixel |
| win_y | output | COORD_W | Row of the window |

## Verification
Each result is due two register stages after its pixel: the window register takes the pixel on the sampling edge, and the score register takes the result on the following edge. The bench drives inputs at falling edges. At every falling edge it compares the outputs with a model entry computed two drives earlier, so each stall, frame restart and reference write lands in the expected cycle. Reference writes enter the model when they are driven, because they reach the lane store on the same edge as the window shift. The extreme-value case is read at the edge its score is due, and the held bus is read again one cycle later.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;

  // squared magnitude of the difference of two pixels
  function automatic logic [2*PIX_W-1:0] sq_diff(input pix_t a, input pix_t b);
    logic [2*PIX_W-1:0] mag;
    mag = (a > b) ? {{PIX_W{1'b0}}, a - b} : {{PIX_W{1'b0}}, b - a};
    return mag * mag;
  endfunction
endpackage

// File: rtl/ssd_window_shifter.sv
module ssd_window_shifter import ssd_pkg::*; #(
  parameter int SEG_LEN = 8,
  parameter int ROW_LEN = 24,
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               pix_valid,
  input  pix_t               pix_data,
  output pix_t               win_q [SEG_LEN],
  output logic               win_ok_q,
  output logic [COORD_W-1:0] win_x_q,
  output logic [COORD_W-1:0] win_y_q
);
  localparam int COL_W = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1;
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(ROW_LEN - 1);
  localparam logic [COL_W-1:0] FIRST_FULL = COL_W'(SEG_LEN - 1);

  logic [COL_W-1:0]   col_q, col_d;
  logic [COORD_W-1:0] row_q, row_d;
  logic               ok_d;
  logic [COORD_W-1:0] x_d, y_d;
  pix_t               win_d [SEG_LEN];
  logic               accept;

  assign accept = pix_valid & ~frame_start;

  // window shift: oldest pixel at index 0, newest enters at the top
  generate
    for (genvar i = 0; i < SEG_LEN - 1; i++) begin : g_shift
      assign win_d[i] = win_q[i+1];
    end
  endgenerate
  assign win_d[SEG_LEN-1] = pix_data;

  always_comb begin
    col_d = col_q;
    row_d = row_q;
    ok_d  = 1'b0;
    x_d   = win_x_q;
    y_d   = win_y_q;
    if (frame_start) begin
      col_d = '0;
      row_d = '0;
    end else if (accept) begin
      if (col_q >= FIRST_FULL) begin
        ok_d = 1'b1;
        x_d  = COORD_W'(col_q - FIRST_FULL);
        y_d  = row_q;
      end
      if (col_q == LAST_COL) begin
        col_d = '0;
        row_d = row_q + COORD_W'(1);
      end else begin
        col_d = col_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= '0;
      row_q    <= '0;
      win_ok_q <= 1'b0;
      win_x_q  <= '0;
      win_y_q  <= '0;
    end else begin
      col_q    <= col_d;
      row_q    <= row_d;
      win_ok_q <= ok_d;
      win_x_q  <= x_d;
      win_y_q  <= y_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_LEN; i++) win_q[i] <= '0;
    end else if (accept) begin
      for (int i = 0; i < SEG_LEN; i++) win_q[i] <= win_d[i];
    end
  end

  // R7
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (col_q == '0 && row_q == '0 && !win_ok_q));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !frame_start) |=> ($stable(col_q) && $stable(row_q) && !win_ok_q));

  // R10
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL);

  // R10
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && col_q == LAST_COL) |=> (col_q == '0 && row_q == $past(row_q) + COORD_W'(1)));
endmodule

// File: rtl/ssd_lane.sv
module ssd_lane import ssd_pkg::*; #(
  parameter int SEG_LEN = 8,
  parameter int SCORE_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [((SEG_LEN > 1) ? $clog2(SEG_LEN) : 1)-1:0] load_pos,
  input  pix_t               load_pix,
  input  pix_t               win [SEG_LEN],
  output logic [SCORE_W-1:0] score
);
  localparam int POS_W = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1;

  pix_t ref_q [SEG_LEN];
  pix_t ref_d [SEG_LEN];

  always_comb begin
    for (int i = 0; i < SEG_LEN; i++) begin
      ref_d[i] = ref_q[i];
      if (load_en && load_pos == POS_W'(i)) ref_d[i] = load_pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SEG_LEN; i++) ref_q[i] <= '0;
    end else if (load_en) begin
      for (int i = 0; i < SEG_LEN; i++) ref_q[i] <= ref_d[i];
    end
  end

  always_comb begin
    score = '0;
    for (int i = 0; i < SEG_LEN; i++) begin
      score = score + SCORE_W'(sq_diff(ref_q[i], win[i]));
    end
  end

  generate
    for (genvar p = 0; p < SEG_LEN; p++) begin : g_hold
      // R9
      ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && load_pos == POS_W'(p)) |=> $stable(ref_q[p]));
    end
  endgenerate
endmodule

// File: rtl/ssd_line_matcher.sv
module ssd_line_matcher import ssd_pkg::*; #(
  parameter int NUM_REF = 8,
  parameter int SEG_LEN = 8,
  parameter int ROW_LEN = 24,
  parameter int COORD_W = 10,
  localparam int SCORE_W = 2 * PIX_W + $clog2(SEG_LEN),
  localparam int REF_W   = (NUM_REF > 1) ? $clog2(NUM_REF) : 1,
  localparam int POS_W   = (SEG_LEN > 1) ? $clog2(SEG_LEN) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_start,
  input  logic                       pix_valid,
  input  logic [7:0]                 pix_data,
  input  logic                       ref_load,
  input  logic [REF_W-1:0]           ref_idx,
  input  logic [POS_W-1:0]           ref_pos,
  input  logic [7:0]                 ref_pix,
  output logic                       score_valid,
  output logic [NUM_REF*SCORE_W-1:0] score_bus,
  output logic [COORD_W-1:0]         win_x,
  output logic [COORD_W-1:0]         win_y
);
  localparam logic [SCORE_W-1:0] MAX_SCORE = SCORE_W'(SEG_LEN * 255 * 255);

  pix_t                       win [SEG_LEN];
  logic                       win_ok;
  logic [COORD_W-1:0]         wx, wy;
  logic [NUM_REF*SCORE_W-1:0] lane_scores;

  logic                       valid_d;
  logic [NUM_REF*SCORE_W-1:0] bus_d;
  logic [COORD_W-1:0]         x_d, y_d;

  ssd_window_shifter #(
    .SEG_LEN (SEG_LEN),
    .ROW_LEN (ROW_LEN),
    .COORD_W (COORD_W)
  ) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .win_q       (win),
    .win_ok_q    (win_ok),
    .win_x_q     (wx),
    .win_y_q     (wy)
  );

  generate
    for (genvar k = 0; k < NUM_REF; k++) begin : g_lane
      logic lane_load;
      assign lane_load = ref_load && (ref_idx == REF_W'(k));

      ssd_lane #(
        .SEG_LEN (SEG_LEN),
        .SCORE_W (SCORE_W)
      ) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (lane_load),
        .load_pos (ref_pos),
        .load_pix (ref_pix),
        .win      (win),
        .score    (lane_scores[k*SCORE_W +: SCORE_W])
      );

      // R8
      score_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        score_valid |-> (score_bus[k*SCORE_W +: SCORE_W] <= MAX_SCORE));
    end
  endgenerate

  // output stage: next state
  always_comb begin
    valid_d = win_ok;
    bus_d   = score_bus;
    x_d     = win_x;
    y_d     = win_y;
    if (win_ok) begin
      bus_d = lane_scores;
      x_d   = wx;
      y_d   = wy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      score_valid <= 1'b0;
      score_bus   <= '0;
      win_x       <= '0;
      win_y       <= '0;
    end else begin
      score_valid <= valid_d;
      score_bus   <= bus_d;
      win_x       <= x_d;
      win_y       <= y_d;
    end
  end

  // R3
  win_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid |-> (int'(win_x) <= ROW_LEN - SEG_LEN));

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |=> score_valid);

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_ok |=> $stable(score_bus));
endmodule

// File: tb/sim_ssd_line_matcher.sv
module sim_ssd_line_matcher;
  localparam int K  = 8;
  localparam int B  = 8;
  localparam int W  = 24;
  localparam int CW = 10;
  localparam int SW = 19;
  localparam int ROWS = 3;

  // scenario: {pixel multiplier, pixel offset, stall period (0 = none), pixel with frame_start}
  localparam logic [31:0] SCEN [4] = '{
    {8'd7,   8'd3,   8'd0, 8'd0},
    {8'd251, 8'd90,  8'd3, 8'd1},
    {8'd13,  8'd200, 8'd1, 8'd0},
    {8'd1,   8'd0,   8'd5, 8'd1}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, frame_start, pix_valid, ref_load;
  logic [7:0]    pix_data, ref_pix;
  logic [2:0]    ref_idx, ref_pos;
  logic          score_valid;
  logic [K*SW-1:0] score_bus;
  logic [CW-1:0] win_x, win_y;

  ssd_line_matcher #(.NUM_REF(K), .SEG_LEN(B), .ROW_LEN(W), .COORD_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_data(pix_data), .ref_load(ref_load), .ref_idx(ref_idx), .ref_pos(ref_pos),
    .ref_pix(ref_pix), .score_valid(score_valid), .score_bus(score_bus),
    .win_x(win_x), .win_y(win_y)
  );

  int n_chk = 0;
  int n_bad = 0;

  // requirement-level model
  int m_ref [K][B];
  int m_win [B];
  int m_col, m_row;
  bit e1_v, e2_v;
  int e1_x, e1_y, e2_x, e2_y;
  longint e1_s [K];
  longint e2_s [K];

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic step(input bit fs, input bit pv, input int pix,
                      input bit rl, input int ridx, input int rpos, input int rpix);
    @(negedge clk);
    check("R3 R5 R6 R7 score_valid", score_valid, e2_v);
    if (e2_v) begin
      check("R4 R10 win_x", win_x, e2_x);
      check("R4 R10 win_y", win_y, e2_y);
      for (int k = 0; k < K; k++)
        check($sformatf("R2 R9 lane %0d score", k), score_bus[k*SW +: SW], e2_s[k]);
    end
    e2_v = e1_v; e2_x = e1_x; e2_y = e1_y;
    for (int k = 0; k < K; k++) e2_s[k] = e1_s[k];
    if (rl) m_ref[ridx][rpos] = rpix & 255;
    e1_v = 1'b0;
    if (fs) begin
      m_col = 0;
      m_row = 0;
    end else if (pv) begin
      for (int i = 0; i < B - 1; i++) m_win[i] = m_win[i+1];
      m_win[B-1] = pix & 255;
      if (m_col >= B - 1) begin
        e1_v = 1'b1;
        e1_x = m_col - (B - 1);
        e1_y = m_row;
        for (int k = 0; k < K; k++) begin
          e1_s[k] = 0;
          for (int i = 0; i < B; i++)
            e1_s[k] += longint'((m_ref[k][i] - m_win[i]) * (m_ref[k][i] - m_win[i]));
        end
      end
      m_col++;
      if (m_col == W) begin
        m_col = 0;
        m_row++;
      end
    end
    frame_start = fs; pix_valid = pv; pix_data = 8'(pix);
    ref_load = rl; ref_idx = 3'(ridx); ref_pos = 3'(rpos); ref_pix = 8'(rpix);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 0, 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; pix_valid = 1'b0; pix_data = '0;
    ref_load = 1'b0; ref_idx = '0; ref_pos = '0; ref_pix = '0;
    m_col = 0; m_row = 0; e1_v = 0; e2_v = 0;
    for (int k = 0; k < K; k++) begin
      e1_s[k] = 0; e2_s[k] = 0;
      for (int i = 0; i < B; i++) m_ref[k][i] = 0;
    end
    for (int i = 0; i < B; i++) m_win[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 score_valid in reset", score_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 score_valid after reset", score_valid, 0);
    check("R1 win_x after reset", win_x, 0);
    check("R1 win_y after reset", win_y, 0);
    check("R1 score_bus zero", (score_bus == '0) ? 1 : 0, 1);

    // vector table walk
    for (int s = 0; s < 4; s++) begin
      int mul, add, per;
      bit fpix;
      mul  = int'(SCEN[s][31:24]);
      add  = int'(SCEN[s][23:16]);
      per  = int'(SCEN[s][15:8]);
      fpix = SCEN[s][0];
      for (int k = 0; k < K; k++)
        for (int i = 0; i < B; i++)
          step(1'b0, 1'b0, 0, 1'b1, k, i, (k * 29 + i * (mul + 5) + add * 3) & 255);
      step(1'b1, fpix, 8'hAA, 1'b0, 0, 0, 0);
      for (int idx = 0; idx < ROWS * W; idx++) begin
        int px;
        px = (idx * mul + add + ((idx * idx) >> 3)) & 255;
        if (idx == 30) step(1'b0, 1'b1, px, 1'b1, 3, 2, 8'h5A);
        else           step(1'b0, 1'b1, px, 1'b0, 0, 0, 0);
        if (per != 0 && (idx % per) == per - 1) idle();
      end
      idle();
      idle();
    end

    // frame restart in the middle of a row
    step(1'b1, 1'b0, 0, 1'b0, 0, 0, 0);
    for (int idx = 0; idx < 12; idx++) step(1'b0, 1'b1, idx * 11, 1'b0, 0, 0, 0);
    step(1'b1, 1'b1, 8'h33, 1'b0, 0, 0, 0);
    for (int idx = 0; idx < 10; idx++) step(1'b0, 1'b1, 255 - idx * 7, 1'b0, 0, 0, 0);
    idle();
    idle();

    // extreme value: lane 0 all zero against an all-white window
    for (int i = 0; i < B; i++) step(1'b0, 1'b0, 0, 1'b1, 0, i, 0);
    step(1'b1, 1'b0, 0, 1'b0, 0, 0, 0);
    for (int i = 0; i < B; i++) step(1'b0, 1'b1, 255, 1'b0, 0, 0, 0);
    idle();
    idle();
    check("R8 largest lane score", score_bus[0 +: SW], 520200);
    idle();
    check("R8 score held while not valid", score_bus[0 +: SW], 520200);
    check("R5 strobe lasts one cycle", score_valid, 0);
    idle();

    report();
  end
endmodule